// File: doc/BRIEF.md
# Active-Matrix LCD Raster Timing Controller

This block generates the scan timing and the pixel path for a thin-film-transistor panel that takes 16-bit direct colour. It pulls RGB565 words from an upstream FIFO, of the kind a frame-buffer fetch engine fills, and puts them on a 16-bit data bus. Alongside the data it drives a continuously toggling pixel clock, a horizontal sync, a vertical sync and a data-enable. No palette or dither stage sits between the FIFO and the bus.

A line is a horizontal sync pulse, then a leading wait, then the active pixels, then a trailing wait. A frame has the same four-part structure counted in lines: the vertical sync, a leading wait, the active lines, and a trailing wait. Every length and all three polarities come from configuration inputs. These inputs are captured only when a frame begins, so software may change them at any time without tearing the picture. A typical panel setting is as follows:
- 640 active pixels by 480 active lines.
- A 46-clock horizontal sync, a 96-clock leading wait and a 4-clock trailing wait on each line.
- A 1-line vertical sync, a 35-line leading wait and no trailing wait on each frame.
- Both syncs active high.

Top module: `lcd_raster_ctrl`

## Requirements
- R1: After reset the pixel clock pin toggles on every `clk` cycle. It equals an internal phase bit XOR `cfg_pclk_inv`. The phase bit is 0 in the first cycle after reset. All raster outputs change only on the edge where that phase returns from 1 to 0, which is one pixel period of two `clk` cycles.
- R2: Each line occupies `h_sync + h_lead + h_active + h_trail` pixel periods in that order. `hsync_o` is in its asserted level exactly during the first `h_sync` of them.
- R3: Each frame occupies `v_sync + v_lead + v_active + v_trail` lines in that order. `vsync_o` is in its asserted level for every pixel of the first `v_sync` lines. After the last pixel of the last line, the next pixel is pixel 0 of line 0.
- R4: `de_o` is 1 only for pixels that lie in both the active pixel span and the active line span. While `de_o` is 0, `data_o` is 0.
- R5: In the pixel period before an active pixel, exactly one FIFO word is popped (`fifo_rd_o` high for one `clk` cycle), provided the FIFO is not empty. That word appears unchanged on `data_o` for that pixel. Bits 15:11 are red, 10:5 are green and 4:0 are blue, passed through without change.
- R6: If the FIFO is empty for an active pixel, nothing is popped and `data_o` repeats the most recently popped word (0 if none since reset). `underrun_o` then becomes 1 and stays 1 until reset.
- R7: `cfg_hs_high` = 1 makes `hsync_o` high while asserted and low otherwise; 0 inverts this. `cfg_vs_high` does the same for `vsync_o`.
- R8: All `cfg_*` inputs are sampled only on the pixel edge that starts a frame, including the first pixel edge after reset. A change in the middle of a frame has no effect on the outputs until the next frame starts.
- R9: While `rst_n` is low, `pclk_o`, `hsync_o`, `vsync_o`, `de_o`, `data_o`, `fifo_rd_o` and `underrun_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_active | input | H_W | Active pixels per line (at least 1) |
| cfg_h_sync | input | H_W | Horizontal sync width in pixels |
| cfg_h_lead | input | H_W | Wait after horizontal sync, in pixels |
| cfg_h_trail | input | H_W | Wait after the active pixels, in pixels |
| cfg_v_active | input | V_W | Active lines per frame (at least 1) |
| cfg_v_sync | input | V_W | Vertical sync width in lines |
| cfg_v_lead | input | V_W | Wait after vertical sync, in lines |
| cfg_v_trail | input | V_W | Wait after the active lines, in lines |
| cfg_pclk_inv | input | 1 | Inverts the pixel clock pin |
| cfg_hs_high | input | 1 | Horizontal sync asserted high when 1 |
| cfg_vs_high | input | 1 | Vertical sync asserted high when 1 |
| fifo_empty_i | input | 1 | Pixel FIFO has no word |
| fifo_data_i | input | PIX_W | RGB565 word at the FIFO head |
| fifo_rd_o | output | 1 | Pops the FIFO head on this clock edge |
| pclk_o | output | 1 | Continuously running pixel clock |
| hsync_o | output | 1 | Horizontal sync (line clock pin) |
| vsync_o | output | 1 | Vertical sync (frame clock pin) |
| de_o | output | 1 | Data enable (bias pin) |
| data_o | output | PIX_W | Pixel data bus |
| underrun_o | output | 1 | Sticky FIFO underrun flag |

## Verification
Two functions can fall on the same pixel edge: the configuration reload at a frame start, and the decode of the first pixel under the new settings, which may include a new polarity. The bench changes the configuration in the middle of a frame and checks that the outputs keep the old timing and polarity until the wrap. It then checks that the first pixel after the wrap already carries the new sync level. The FIFO underrun and the line wrap can also land together. The bench lets the FIFO run dry partway through a frame, so the hold of the last word and the sticky flag are judged on whatever pixel the drain falls on, including the first active pixel of a line. A behavioural reference model predicts every pin on every cycle.

// File: rtl/lcd_tc_pkg.sv
package lcd_tc_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC,
    SEG_LEAD,
    SEG_ACTIVE,
    SEG_TRAIL
  } seg_e;

  // Which part of a line (or frame) a position falls into.
  function automatic seg_e seg_of(input int unsigned pos,
                                  input int unsigned sync_len,
                                  input int unsigned lead_len,
                                  input int unsigned act_len);
    if (pos < sync_len)                            return SEG_SYNC;
    else if (pos < sync_len + lead_len)            return SEG_LEAD;
    else if (pos < sync_len + lead_len + act_len)  return SEG_ACTIVE;
    else                                           return SEG_TRAIL;
  endfunction

  // Last position of a span made of four consecutive parts.
  function automatic int unsigned span_last(input int unsigned sync_len,
                                            input int unsigned lead_len,
                                            input int unsigned act_len,
                                            input int unsigned trail_len);
    return sync_len + lead_len + act_len + trail_len - 1;
  endfunction

endpackage

// File: rtl/lcd_tc_pclkgen.sv
module lcd_tc_pclkgen (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o,
  output logic tick_o
);

  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;
  // The raster advances on the edge that ends the high phase.
  assign tick_o  = phase_q;

  assert_phase_toggles_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/lcd_tc_axis.sv
module lcd_tc_axis #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         clear_i,
  input  logic [W-1:0] sync_len_i,
  input  logic [W-1:0] lead_len_i,
  input  logic [W-1:0] act_len_i,
  input  logic [W-1:0] trail_len_i,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] nxt_o,
  output logic         last_o
);
  import lcd_tc_pkg::*;

  logic [W-1:0] pos_q;

  assign last_o = (32'(pos_q) == span_last(32'(sync_len_i), 32'(lead_len_i),
                                           32'(act_len_i), 32'(trail_len_i)));

  always_comb begin
    if (clear_i)      nxt_o = '0;
    else if (step_i)  nxt_o = last_o ? '0 : pos_q + 1'b1;
    else              nxt_o = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= nxt_o;
  end

  assign pos_o = pos_q;

  assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clear_i) |=> (pos_q == $past(pos_q)));

endmodule

// File: rtl/lcd_tc_pixpath.sv
module lcd_tc_pixpath #(
  parameter int unsigned PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             de_next_i,
  input  logic             fifo_empty_i,
  input  logic [PIX_W-1:0] fifo_data_i,
  output logic             fifo_rd_o,
  output logic             de_o,
  output logic [PIX_W-1:0] data_o,
  output logic             underrun_o
);

  logic             de_q;
  logic             und_q;
  logic [PIX_W-1:0] px_q;   // last word taken from the FIFO
  logic [PIX_W-1:0] bus_q;

  assign fifo_rd_o = tick_i && de_next_i && !fifo_empty_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      und_q <= 1'b0;
      px_q  <= '0;
      bus_q <= '0;
    end else if (tick_i) begin
      de_q <= de_next_i;
      if (de_next_i) begin
        if (!fifo_empty_i) begin
          px_q  <= fifo_data_i;
          bus_q <= fifo_data_i;
        end else begin
          bus_q <= px_q;
          und_q <= 1'b1;
        end
      end else begin
        bus_q <= '0;
      end
    end
  end

  assign de_o       = de_q;
  assign data_o     = bus_q;
  assign underrun_o = und_q;

  assert_de_only_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(de_o));

  assert_blank_bus_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> (data_o == '0));

  assert_pop_shows_pixel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |=> (de_o && data_o == $past(fifo_data_i)));

  assert_starve_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && de_next_i && fifo_empty_i) |=> (underrun_o && de_o));

  assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o);

endmodule

// File: rtl/lcd_raster_ctrl.sv
module lcd_raster_ctrl #(
  parameter int unsigned H_W   = 12,
  parameter int unsigned V_W   = 11,
  parameter int unsigned PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [H_W-1:0]   cfg_h_active,
  input  logic [H_W-1:0]   cfg_h_sync,
  input  logic [H_W-1:0]   cfg_h_lead,
  input  logic [H_W-1:0]   cfg_h_trail,
  input  logic [V_W-1:0]   cfg_v_active,
  input  logic [V_W-1:0]   cfg_v_sync,
  input  logic [V_W-1:0]   cfg_v_lead,
  input  logic [V_W-1:0]   cfg_v_trail,
  input  logic             cfg_pclk_inv,
  input  logic             cfg_hs_high,
  input  logic             cfg_vs_high,
  input  logic             fifo_empty_i,
  input  logic [PIX_W-1:0] fifo_data_i,
  output logic             fifo_rd_o,
  output logic             pclk_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [PIX_W-1:0] data_o,
  output logic             underrun_o
);
  import lcd_tc_pkg::*;

  // ---------------------------------------------------------------- pixel clock
  logic phase, tick;

  lcd_tc_pclkgen u_pclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase),
    .tick_o  (tick)
  );

  // ------------------------------------------------------- per-frame shadow set
  logic [H_W-1:0] sh_h_active, sh_h_sync, sh_h_lead, sh_h_trail;
  logic [V_W-1:0] sh_v_active, sh_v_sync, sh_v_lead, sh_v_trail;
  logic           sh_pclk_inv, sh_hs_high, sh_vs_high;
  logic           primed_q;

  logic [H_W-1:0] h_pos, h_nxt;
  logic [V_W-1:0] v_pos, v_nxt;
  logic           h_last, v_last;
  logic           frame_start;
  logic           reload;

  assign frame_start = !primed_q || (h_last && v_last);
  assign reload      = tick && frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q    <= 1'b0;
      sh_h_active <= '0;
      sh_h_sync   <= '0;
      sh_h_lead   <= '0;
      sh_h_trail  <= '0;
      sh_v_active <= '0;
      sh_v_sync   <= '0;
      sh_v_lead   <= '0;
      sh_v_trail  <= '0;
      sh_pclk_inv <= 1'b0;
      sh_hs_high  <= 1'b0;
      sh_vs_high  <= 1'b0;
    end else if (reload) begin
      primed_q    <= 1'b1;
      sh_h_active <= cfg_h_active;
      sh_h_sync   <= cfg_h_sync;
      sh_h_lead   <= cfg_h_lead;
      sh_h_trail  <= cfg_h_trail;
      sh_v_active <= cfg_v_active;
      sh_v_sync   <= cfg_v_sync;
      sh_v_lead   <= cfg_v_lead;
      sh_v_trail  <= cfg_v_trail;
      sh_pclk_inv <= cfg_pclk_inv;
      sh_hs_high  <= cfg_hs_high;
      sh_vs_high  <= cfg_vs_high;
    end
  end

  // Settings that govern the pixel being entered on this tick.
  logic [H_W-1:0] eff_h_active, eff_h_sync, eff_h_lead;
  logic [V_W-1:0] eff_v_active, eff_v_sync, eff_v_lead;
  logic           eff_hs_high, eff_vs_high;

  assign eff_h_active = frame_start ? cfg_h_active : sh_h_active;
  assign eff_h_sync   = frame_start ? cfg_h_sync   : sh_h_sync;
  assign eff_h_lead   = frame_start ? cfg_h_lead   : sh_h_lead;
  assign eff_v_active = frame_start ? cfg_v_active : sh_v_active;
  assign eff_v_sync   = frame_start ? cfg_v_sync   : sh_v_sync;
  assign eff_v_lead   = frame_start ? cfg_v_lead   : sh_v_lead;
  assign eff_hs_high  = frame_start ? cfg_hs_high  : sh_hs_high;
  assign eff_vs_high  = frame_start ? cfg_vs_high  : sh_vs_high;

  // ---------------------------------------------------------- position counters
  lcd_tc_axis #(.W(H_W)) u_hcnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (tick),
    .clear_i     (reload),
    .sync_len_i  (sh_h_sync),
    .lead_len_i  (sh_h_lead),
    .act_len_i   (sh_h_active),
    .trail_len_i (sh_h_trail),
    .pos_o       (h_pos),
    .nxt_o       (h_nxt),
    .last_o      (h_last)
  );

  lcd_tc_axis #(.W(V_W)) u_vcnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (tick && h_last),
    .clear_i     (reload),
    .sync_len_i  (sh_v_sync),
    .lead_len_i  (sh_v_lead),
    .act_len_i   (sh_v_active),
    .trail_len_i (sh_v_trail),
    .pos_o       (v_pos),
    .nxt_o       (v_nxt),
    .last_o      (v_last)
  );

  // ------------------------------------------------------ decode of next pixel
  seg_e h_seg_n, v_seg_n;
  logic hs_next, vs_next, de_next;

  assign h_seg_n = seg_of(32'(h_nxt), 32'(eff_h_sync), 32'(eff_h_lead), 32'(eff_h_active));
  assign v_seg_n = seg_of(32'(v_nxt), 32'(eff_v_sync), 32'(eff_v_lead), 32'(eff_v_active));
  assign hs_next = (h_seg_n == SEG_SYNC);
  assign vs_next = (v_seg_n == SEG_SYNC);
  assign de_next = (h_seg_n == SEG_ACTIVE) && (v_seg_n == SEG_ACTIVE);

  logic hs_q, vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else if (tick) begin
      hs_q <= hs_next ? eff_hs_high : ~eff_hs_high;
      vs_q <= vs_next ? eff_vs_high : ~eff_vs_high;
    end
  end

  // ------------------------------------------------------------- pixel path
  lcd_tc_pixpath #(.PIX_W(PIX_W)) u_pix (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .de_next_i    (de_next),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_rd_o    (fifo_rd_o),
    .de_o         (de_o),
    .data_o       (data_o),
    .underrun_o   (underrun_o)
  );

  assign pclk_o  = phase ^ sh_pclk_inv;
  assign hsync_o = hs_q;
  assign vsync_o = vs_q;

  // ------------------------------------------------------------- assertions
  assert_line_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && h_last && primed_q) |=> (h_pos == '0));

  assert_frame_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && h_last && v_last && primed_q) |=> (h_pos == '0 && v_pos == '0));

  assert_de_not_in_hsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (hsync_o == ~sh_hs_high));

  assert_de_not_in_vsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (vsync_o == ~sh_vs_high));

  assert_settings_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !reload) |=> $stable(sh_h_active) && $stable(sh_v_active)
                              && $stable(sh_hs_high) && $stable(sh_vs_high));

endmodule

// File: tb/test_lcd_raster_ctrl.sv
`timescale 1ns/1ps
module test_lcd_raster_ctrl;

  localparam int unsigned H_W = 12;
  localparam int unsigned V_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [H_W-1:0] cfg_h_active, cfg_h_sync, cfg_h_lead, cfg_h_trail;
  logic [V_W-1:0] cfg_v_active, cfg_v_sync, cfg_v_lead, cfg_v_trail;
  logic cfg_pclk_inv, cfg_hs_high, cfg_vs_high;
  logic fifo_empty_i = 1'b1;
  logic [15:0] fifo_data_i = '0;
  logic fifo_rd_o, pclk_o, hsync_o, vsync_o, de_o, underrun_o;
  logic [15:0] data_o;

  lcd_raster_ctrl #(.H_W(H_W), .V_W(V_W), .PIX_W(16)) i_lcd_raster_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_active(cfg_h_active), .cfg_h_sync(cfg_h_sync),
    .cfg_h_lead(cfg_h_lead), .cfg_h_trail(cfg_h_trail),
    .cfg_v_active(cfg_v_active), .cfg_v_sync(cfg_v_sync),
    .cfg_v_lead(cfg_v_lead), .cfg_v_trail(cfg_v_trail),
    .cfg_pclk_inv(cfg_pclk_inv), .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high),
    .fifo_empty_i(fifo_empty_i), .fifo_data_i(fifo_data_i), .fifo_rd_o(fifo_rd_o),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .data_o(data_o), .underrun_o(underrun_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Source of pixel words, standing in for the frame-buffer fetch side.
  logic [15:0] src_q[$];
  int pushed = 0;

  // Behavioural reference state.
  int m_phase = 0, m_primed = 0, hx = 0, vy = 0;
  int s_hs = 0, s_hl = 0, s_ha = 0, s_ht = 0, s_vs = 0, s_vl = 0, s_va = 0, s_vt = 0;
  bit s_pinv = 0, s_hsh = 0, s_vsh = 0;
  bit exp_hs = 0, exp_vs = 0, exp_de = 0, exp_und = 0, exp_pclk = 0, exp_rd = 0;
  logic [15:0] exp_data = '0, m_last = '0;

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    if (act !== exp) begin
      miscompares++;
      if (miscompares < 30)
        $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  // Reference model: advances on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_primed = 0; hx = 0; vy = 0;
      s_pinv = 0; s_hsh = 0; s_vsh = 0;
      exp_hs = 0; exp_vs = 0; exp_de = 0; exp_und = 0; exp_data = '0; m_last = '0;
    end else begin
      exp_rd = 0;
      if (m_phase == 1) begin : pixel_step
        int hlast, vlast;
        bit in_h, in_v;
        hlast = s_hs + s_hl + s_ha + s_ht - 1;
        vlast = s_vs + s_vl + s_va + s_vt - 1;
        if (!m_primed || (hx == hlast && vy == vlast)) begin
          // R8: settings taken only here
          s_hs = cfg_h_sync; s_hl = cfg_h_lead; s_ha = cfg_h_active; s_ht = cfg_h_trail;
          s_vs = cfg_v_sync; s_vl = cfg_v_lead; s_va = cfg_v_active; s_vt = cfg_v_trail;
          s_pinv = cfg_pclk_inv; s_hsh = cfg_hs_high; s_vsh = cfg_vs_high;
          m_primed = 1; hx = 0; vy = 0;
        end else if (hx == hlast) begin
          hx = 0; vy++;
        end else begin
          hx++;
        end
        exp_hs = (hx < s_hs) ? s_hsh : !s_hsh;
        exp_vs = (vy < s_vs) ? s_vsh : !s_vsh;
        in_h = (hx >= s_hs + s_hl) && (hx < s_hs + s_hl + s_ha);
        in_v = (vy >= s_vs + s_vl) && (vy < s_vs + s_vl + s_va);
        exp_de = in_h && in_v;
        if (exp_de) begin
          if (!fifo_empty_i) begin
            exp_rd = 1; m_last = fifo_data_i; exp_data = fifo_data_i;
          end else begin
            exp_und = 1; exp_data = m_last;
          end
        end else begin
          exp_data = '0;
        end
      end
      chk("R5", "fifo_rd", {15'b0, fifo_rd_o}, {15'b0, exp_rd});
      if (fifo_rd_o && src_q.size() > 0) void'(src_q.pop_front());
      m_phase = 1 - m_phase;
      exp_pclk = m_phase[0] ^ s_pinv;
    end
  end

  // Compare on the falling edge, then present the FIFO head for the next edge.
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (!rst_n) begin
        chk("R9", "reset outputs",
            {9'b0, pclk_o, hsync_o, vsync_o, de_o, fifo_rd_o, underrun_o, |data_o}, 16'h0);
      end else begin
        chk("R1", "pclk", {15'b0, pclk_o}, {15'b0, exp_pclk});
        chk("R2/R7/R8", "hsync", {15'b0, hsync_o}, {15'b0, exp_hs});
        chk("R3/R7/R8", "vsync", {15'b0, vsync_o}, {15'b0, exp_vs});
        chk("R4", "de", {15'b0, de_o}, {15'b0, exp_de});
        chk("R5/R6", "data", data_o, exp_data);
        chk("R6", "underrun", {15'b0, underrun_o}, {15'b0, exp_und});
      end
      fifo_empty_i = (src_q.size() == 0);
      fifo_data_i  = (src_q.size() > 0) ? src_q[0] : 16'h0;
    end
  end

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      // mix of pure red, green, blue fields and mixed words
      case (pushed % 4)
        0: src_q.push_back(16'hF800);
        1: src_q.push_back(16'h07E0);
        2: src_q.push_back(16'h001F);
        default: src_q.push_back(16'(pushed * 16'h0841) ^ 16'h5A5A);
      endcase
      pushed++;
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int hs, hl, ha, ht, vs, vl, va, vt,
                         input bit pinv, hsh, vsh);
    cfg_h_sync = H_W'(hs); cfg_h_lead = H_W'(hl);
    cfg_h_active = H_W'(ha); cfg_h_trail = H_W'(ht);
    cfg_v_sync = V_W'(vs); cfg_v_lead = V_W'(vl);
    cfg_v_active = V_W'(va); cfg_v_trail = V_W'(vt);
    cfg_pclk_inv = pinv; cfg_hs_high = hsh; cfg_vs_high = vsh;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    // R1 R2 R3 R4: line 2+3+8+1, frame 1+2+4+0, syncs high
    set_cfg(2, 3, 8, 1, 1, 2, 4, 0, 1'b0, 1'b1, 1'b1);
    run(4);                       // R9 reset state compared here
    rst_n = 1'b1;
    push_words(80);
    run(250);
    // R8: change mid-frame; old timing must hold until the wrap. R7 low syncs.
    set_cfg(1, 0, 5, 2, 2, 0, 3, 1, 1'b1, 1'b0, 1'b0);
    run(200);
    // R6: source runs dry during this stretch, then refills
    push_words(40);
    run(500);
    push_words(30);
    run(300);
    // R2 R3 R4: zero-length waits, one active pixel per frame
    set_cfg(1, 0, 1, 0, 1, 0, 1, 0, 1'b0, 1'b1, 1'b0);
    push_words(60);
    run(200);
    // R5: wide line, FIFO kept full
    set_cfg(3, 2, 20, 2, 1, 1, 5, 2, 1'b0, 1'b1, 1'b1);
    push_words(400);
    run(800);
    finish_run();
  end

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule